// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block owns a small synchronous word memory and performs indivisible read-modify-write operations on it for several requesters. A requester presents an opcode, a word address and two operands (`a`, `b`). The unit reads the addressed word, computes a result, writes it back when the operation's condition allows, and returns the value the word held before the operation. Requesters use that returned value to tell whether a conditional operation took effect.

Test-and-set, four fetch-and-op variants (increment, decrement, add, subtract), swap and compare-and-swap are supported, as well as plain loads and stores. Every access, plain or atomic, passes one round-robin arbiter, and a new request is accepted only when the previous sequence has fully finished. A plain store can therefore never fall between the read and the write of an atomic sequence.

Top module: `amo_unit`

## Requirements
- R1: After reset no response is asserted and every memory word reads as zero.
- R2: Opcode 0 (load) returns the word and leaves it unchanged. Opcode 1 (store) writes `a` and returns the previous word.
- R3: Opcode 2 (test-and-set) writes `a` only when the word read is zero; it always returns the word read.
- R4: Opcodes 3, 4, 5 and 6 write back old+1, old-1, old+a and old-a respectively, with wrap-around modulo 2^DW, and return the old word.
- R5: Opcode 7 (swap) writes `a` and returns the old word.
- R6: Opcode 8 (compare-and-swap) writes `b` only when the word equals `a`; `rsp_aux` carries `a` on a match and `b` otherwise.
- R7: At most one request is accepted at a time. A request whose sequence writes memory responds on the 4th cycle after the accepting edge; one that does not write responds on the 3rd. No `req_ready` is high while a sequence is in flight.
- R8: Requests are granted round-robin: after requester g is served, the search for the next grant begins at g+1 (mod NREQ). After reset requester 0 ranks first.
- R9: Concurrent atomic increments of one word are fully serialized: each requester sees a distinct old value and the final word equals the number of increments.
- R10: Opcodes 9 to 15 act as loads: they return the word and do not modify memory.
- R11: The response strobe `rsp_valid` is one-hot and names the requester that issued the operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request present, per requester |
| req_op | input | NREQ x 4 | Opcode, per requester |
| req_addr | input | NREQ x AW | Word address, per requester |
| req_a | input | NREQ x DW | First operand, per requester |
| req_b | input | NREQ x DW | Second operand, per requester |
| req_ready | output | NREQ | Request accepted at this clock edge |
| rsp_valid | output | NREQ | One-cycle response strobe to the issuer |
| rsp_data | output | DW | Word value before the operation |
| rsp_aux | output | DW | Compare-and-swap register result |

## Verification
The assertions watch the serialization on every cycle: at most one ready line, one-hot responses, no acceptance in the cycle after an acceptance, every memory write preceded two cycles earlier by a read of the same sequence and followed by a response. The arithmetic of each opcode, the success and failure paths of the conditional operations, wrap-around, the latency difference between writing and non-writing sequences, the round-robin order and the contention result are shown only by the bench's directed scenarios, which compare returned and stored words with values worked out from the requirements.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 4'd0,
    OP_STORE = 4'd1,
    OP_TAS   = 4'd2,
    OP_FINC  = 4'd3,
    OP_FDEC  = 4'd4,
    OP_FADD  = 4'd5,
    OP_FSUB  = 4'd6,
    OP_SWAP  = 4'd7,
    OP_CAS   = 4'd8
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_CALC  = 3'd2,
    ST_WRITE = 3'd3,
    ST_RESP  = 3'd4
  } amo_state_e;

endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   old_val,
  input  logic [DW-1:0]   a_val,
  input  logic [DW-1:0]   b_val,
  output logic [DW-1:0]   new_val,
  output logic [DW-1:0]   aux_val,
  output logic            wr_en
);

  localparam int RW = 2 * DW + 1;

  // Packs {write enable, new word, aux result}
  function automatic logic [RW-1:0] eval_op(
    input logic [OP_W-1:0] o,
    input logic [DW-1:0]   old_w,
    input logic [DW-1:0]   a_w,
    input logic [DW-1:0]   b_w
  );
    logic          we;
    logic [DW-1:0] nv;
    logic [DW-1:0] ax;
    we = 1'b0;
    nv = old_w;
    ax = '0;
    case (o)
      OP_STORE: begin we = 1'b1; nv = a_w; end
      OP_TAS:   begin we = (old_w == '0); nv = a_w; end
      OP_FINC:  begin we = 1'b1; nv = old_w + DW'(1); end
      OP_FDEC:  begin we = 1'b1; nv = old_w - DW'(1); end
      OP_FADD:  begin we = 1'b1; nv = old_w + a_w; end
      OP_FSUB:  begin we = 1'b1; nv = old_w - a_w; end
      OP_SWAP:  begin we = 1'b1; nv = a_w; end
      OP_CAS:   begin
        we = (old_w == a_w);
        nv = b_w;
        ax = we ? a_w : b_w;
      end
      default:  begin we = 1'b0; end
    endcase
    return {we, nv, ax};
  endfunction

  always_comb begin
    {wr_en, new_val, aux_val} = eval_op(op, old_val, a_val, b_val);
  end

endmodule

// File: rtl/amo_rr_arb.sv
module amo_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         take,
  output logic [N-1:0] grant
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q;
  logic [IW-1:0] win_idx;

  always_comb begin
    logic found;
    int   idx;
    grant = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(last_q) + 1 + k) % N;
      if (!found && req[idx]) begin
        grant[idx] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    win_idx = last_q;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) win_idx = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= IW'(N - 1);
    else if (take) last_q <= win_idx;
  end

endmodule

// File: rtl/amo_mem.sv
module amo_mem #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words_q[i] <= '0;
      rdata <= '0;
    end else begin
      if (rd_en) rdata <= words_q[addr];
      if (wr_en) words_q[addr] <= wdata;
    end
  end

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int DW   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NREQ-1:0]            req_valid,
  input  logic [NREQ-1:0][OP_W-1:0]  req_op,
  input  logic [NREQ-1:0][AW-1:0]    req_addr,
  input  logic [NREQ-1:0][DW-1:0]    req_a,
  input  logic [NREQ-1:0][DW-1:0]    req_b,
  output logic [NREQ-1:0]            req_ready,
  output logic [NREQ-1:0]            rsp_valid,
  output logic [DW-1:0]              rsp_data,
  output logic [DW-1:0]              rsp_aux
);

  amo_state_e state_q, state_d;

  logic [NREQ-1:0] grant;
  logic            idle;
  logic            accept;
  logic            mem_rd;
  logic            mem_we;
  logic [DW-1:0]   mem_rdata;

  logic [OP_W-1:0] sel_op;
  logic [AW-1:0]   sel_addr;
  logic [DW-1:0]   sel_a, sel_b;

  logic [OP_W-1:0] op_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   a_q, b_q;
  logic [NREQ-1:0] id_q;
  logic [DW-1:0]   old_q, new_q, aux_q;

  logic [DW-1:0]   alu_new, alu_aux;
  logic            alu_we;

  assign idle      = (state_q == ST_IDLE);
  assign req_ready = idle ? grant : '0;
  assign accept    = |(req_valid & req_ready);
  assign mem_rd    = (state_q == ST_READ);
  assign mem_we    = (state_q == ST_WRITE);

  amo_rr_arb #(.N(NREQ)) arb_i (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_valid),
    .take  (accept),
    .grant (grant)
  );

  always_comb begin
    sel_op   = '0;
    sel_addr = '0;
    sel_a    = '0;
    sel_b    = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (grant[i]) begin
        sel_op   = req_op[i];
        sel_addr = req_addr[i];
        sel_a    = req_a[i];
        sel_b    = req_b[i];
      end
    end
  end

  amo_mem #(.AW(AW), .DW(DW)) mem_i (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (mem_rd),
    .wr_en (mem_we),
    .addr  (addr_q),
    .wdata (new_q),
    .rdata (mem_rdata)
  );

  amo_alu #(.DW(DW)) alu_i (
    .op      (op_q),
    .old_val (mem_rdata),
    .a_val   (a_q),
    .b_val   (b_q),
    .new_val (alu_new),
    .aux_val (alu_aux),
    .wr_en   (alu_we)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = ST_READ;
      ST_READ:  state_d = ST_CALC;
      ST_CALC:  state_d = alu_we ? ST_WRITE : ST_RESP;
      ST_WRITE: state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      a_q     <= '0;
      b_q     <= '0;
      id_q    <= '0;
      old_q   <= '0;
      new_q   <= '0;
      aux_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q   <= sel_op;
        addr_q <= sel_addr;
        a_q    <= sel_a;
        b_q    <= sel_b;
        id_q   <= grant;
      end
      if (state_q == ST_CALC) begin
        old_q <= mem_rdata;
        new_q <= alu_new;
        aux_q <= alu_aux;
      end
    end
  end

  assign rsp_valid = (state_q == ST_RESP) ? id_q : '0;
  assign rsp_data  = old_q;
  assign rsp_aux   = aux_q;

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int NREQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_valid,
  input logic [NREQ-1:0] req_ready,
  input logic [NREQ-1:0] rsp_valid,
  input logic            mem_rd,
  input logic            mem_we
);

  logic accept;
  assign accept = |(req_valid & req_ready);

  a_r7_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  a_r11_onehot_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));

  a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (req_ready == '0));

  a_r7_no_ready_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid != '0) |-> (req_ready == '0));

  a_r9_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_rd, 2));

  a_r7_rsp_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (rsp_valid != '0));

endmodule

bind amo_unit amo_unit_chk #(.NREQ(NREQ)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_rd    (mem_rd),
  .mem_we    (mem_we)
);

// File: tb/amo_unit_tb_top.sv
`timescale 1ns/1ps
module amo_unit_tb_top;

  localparam int NREQ = 4;
  localparam int AW   = 4;
  localparam int DW   = 16;

  localparam logic [3:0] C_LOAD = 4'd0, C_STORE = 4'd1, C_TAS = 4'd2,
                         C_FINC = 4'd3, C_FDEC = 4'd4, C_FADD = 4'd5,
                         C_FSUB = 4'd6, C_SWAP = 4'd7, C_CAS = 4'd8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREQ-1:0]           valid = '0;
  logic [NREQ-1:0][3:0]      op    = '0;
  logic [NREQ-1:0][AW-1:0]   addr  = '0;
  logic [NREQ-1:0][DW-1:0]   a     = '0;
  logic [NREQ-1:0][DW-1:0]   b     = '0;
  logic [NREQ-1:0]           req_ready;
  logic [NREQ-1:0]           rsp_valid;
  logic [DW-1:0]             rsp_data;
  logic [DW-1:0]             rsp_aux;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [DW-1:0]   g_old, g_aux;
  logic [NREQ-1:0] g_rspv;
  int              g_lat;

  always #2 clk = ~clk;

  amo_unit #(.NREQ(NREQ), .AW(AW), .DW(DW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (valid),
    .req_op    (op),
    .req_addr  (addr),
    .req_a     (a),
    .req_b     (b),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_aux   (rsp_aux)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input int id, input logic [3:0] o, input logic [AW-1:0] ad,
                       input logic [DW-1:0] av, input logic [DW-1:0] bv);
    int w;
    @(negedge clk);
    op[id] = o; addr[id] = ad; a[id] = av; b[id] = bv; valid[id] = 1'b1;
    #1;
    w = 0;
    while (!req_ready[id] && w < 50) begin
      @(negedge clk); #1; w++;
    end
    @(negedge clk);
    valid[id] = 1'b0;
    g_lat = 1;
    #1;
    while (rsp_valid == '0 && g_lat < 20) begin
      @(negedge clk); #1; g_lat++;
    end
    g_old = rsp_data; g_aux = rsp_aux; g_rspv = rsp_valid;
  endtask

  task automatic expect_load(input logic [AW-1:0] ad, input logic [DW-1:0] exp, input string tag);
    do_op(0, C_LOAD, ad, '0, '0);
    check(g_old == exp, tag, g_old, exp);
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    check(rsp_valid == '0, "R1 no response after reset", rsp_valid, 0);
    check(req_ready == '0, "R1 no ready without request", req_ready, 0);
    expect_load(4'd5, 16'h0000, "R1 word zero after reset");
    expect_load(4'd15, 16'h0000, "R1 top word zero after reset");
  endtask

  task automatic t_load_store;
    do_op(0, C_STORE, 4'd3, 16'h1234, '0);
    check(g_old == 16'h0000, "R2 store returns old", g_old, 0);
    check(g_lat == 4, "R7 write latency", g_lat, 4);
    do_op(0, C_LOAD, 4'd3, '0, '0);
    check(g_old == 16'h1234, "R2 load value", g_old, 16'h1234);
    check(g_lat == 3, "R7 no-write latency", g_lat, 3);
    expect_load(4'd3, 16'h1234, "R2 load leaves word");
  endtask

  task automatic t_tas;
    do_op(0, C_TAS, 4'd4, 16'h0001, '0);
    check(g_old == 16'h0000, "R3 tas free old", g_old, 0);
    check(g_lat == 4, "R3 tas success writes", g_lat, 4);
    do_op(0, C_TAS, 4'd4, 16'h0007, '0);
    check(g_old == 16'h0001, "R3 tas held old", g_old, 1);
    check(g_lat == 3, "R3 tas fail no write", g_lat, 3);
    expect_load(4'd4, 16'h0001, "R3 tas held word kept");
  endtask

  task automatic t_fetch;
    do_op(0, C_STORE, 4'd5, 16'hFFFF, '0);
    do_op(0, C_FINC, 4'd5, '0, '0);
    check(g_old == 16'hFFFF, "R4 finc old", g_old, 16'hFFFF);
    expect_load(4'd5, 16'h0000, "R4 finc wraps");
    do_op(0, C_FDEC, 4'd5, '0, '0);
    check(g_old == 16'h0000, "R4 fdec old", g_old, 0);
    expect_load(4'd5, 16'hFFFF, "R4 fdec wraps");
    do_op(0, C_FADD, 4'd5, 16'h0010, '0);
    check(g_old == 16'hFFFF, "R4 fadd old", g_old, 16'hFFFF);
    expect_load(4'd5, 16'h000F, "R4 fadd result");
    do_op(0, C_FSUB, 4'd5, 16'h0020, '0);
    check(g_old == 16'h000F, "R4 fsub old", g_old, 16'h000F);
    expect_load(4'd5, 16'hFFEF, "R4 fsub result");
  endtask

  task automatic t_swap;
    do_op(0, C_STORE, 4'd6, 16'hAAAA, '0);
    do_op(0, C_SWAP, 4'd6, 16'h5555, '0);
    check(g_old == 16'hAAAA, "R5 swap old", g_old, 16'hAAAA);
    expect_load(4'd6, 16'h5555, "R5 swap new");
  endtask

  task automatic t_cas;
    do_op(0, C_STORE, 4'd7, 16'h0042, '0);
    do_op(0, C_CAS, 4'd7, 16'h0041, 16'h0099);
    check(g_old == 16'h0042, "R6 cas miss old", g_old, 16'h42);
    check(g_aux == 16'h0099, "R6 cas miss aux", g_aux, 16'h99);
    check(g_lat == 3, "R6 cas miss no write", g_lat, 3);
    expect_load(4'd7, 16'h0042, "R6 cas miss keeps word");
    do_op(0, C_CAS, 4'd7, 16'h0042, 16'h0099);
    check(g_old == 16'h0042, "R6 cas hit old", g_old, 16'h42);
    check(g_aux == 16'h0042, "R6 cas hit aux", g_aux, 16'h42);
    check(g_lat == 4, "R6 cas hit writes", g_lat, 4);
    expect_load(4'd7, 16'h0099, "R6 cas hit new word");
  endtask

  task automatic t_unused;
    for (int c = 9; c < 16; c += 3) begin
      do_op(0, 4'(c), 4'd7, 16'h1111, 16'h2222);
      check(g_old == 16'h0099, "R10 unused op returns word", g_old, 16'h99);
      check(g_lat == 3, "R10 unused op no write", g_lat, 3);
    end
    expect_load(4'd7, 16'h0099, "R10 word unchanged");
  endtask

  task automatic t_issuer;
    do_op(2, C_LOAD, 4'd3, '0, '0);
    check(g_rspv == 4'b0100, "R11 response to requester 2", g_rspv, 4'b0100);
    check(g_old == 16'h1234, "R11 data to requester 2", g_old, 16'h1234);
    do_op(3, C_LOAD, 4'd6, '0, '0);
    check(g_rspv == 4'b1000, "R11 response to requester 3", g_rspv, 4'b1000);
  endtask

  task automatic t_contend;
    int order [NREQ];
    logic [DW-1:0] seen [NREQ];
    int k, got, pend, n;
    do_op(1, C_LOAD, 4'd9, '0, '0);
    @(negedge clk);
    for (int i = 0; i < NREQ; i++) begin
      op[i] = C_FINC; addr[i] = 4'd9; a[i] = '0; b[i] = '0; valid[i] = 1'b1;
      order[i] = -1; seen[i] = '0;
    end
    #1;
    k = 0; got = 0; pend = -1; n = 0;
    while (got < NREQ && n < 100) begin
      if ($countones(req_ready) > 1)
        check(1'b0, "R7 multiple ready", req_ready, 0);
      for (int i = 0; i < NREQ; i++)
        if (rsp_valid[i]) begin seen[i] = rsp_data; got++; end
      for (int i = 0; i < NREQ; i++)
        if (valid[i] && req_ready[i] && k < NREQ) begin order[k] = i; k++; pend = i; end
      @(negedge clk);
      if (pend >= 0) valid[pend] = 1'b0;
      pend = -1;
      #1;
      n++;
    end
    for (int j = 0; j < NREQ; j++) begin
      check(order[j] == (2 + j) % NREQ, "R8 round-robin grant order", order[j], (2 + j) % NREQ);
      if (order[j] >= 0)
        check(seen[order[j]] == DW'(j), "R9 serialized old value", seen[order[j]], j);
    end
    expect_load(4'd9, 16'd4, "R9 final count");
  endtask

  initial begin
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_store();
    t_tas();
    t_fetch();
    t_swap();
    t_cas();
    t_unused();
    t_issuer();
    t_contend();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule